// File: doc/BRIEF.md
# Table-Programmed Packet Header Parser

This block walks the headers at the front of a packet and reports which protocol headers it found and where each one starts. Header bytes arrive one per cycle on a simple byte stream and are kept in a local buffer. Once the last byte is in, a walk controller visits one parse state per cycle. In each state it records the current header's start offset and a 16-bit key word taken from that header. It then looks the key up, together with the state number, in a writable ternary match table. The matching entry gives the length of the current header, the next state, and where in the next header the following key word sits.

The parse graph is not fixed in logic. Software loads the table entries through a plain address/data/write-enable port while the parser is idle. Protocols can therefore be added, removed or re-ordered without changing the hardware. A typical graph goes from an Ethernet state to IPv4 or IPv6 on the EtherType. From IPv4 it goes to TCP or UDP, or through a custom shim header and then to TCP. The results are a per-state valid vector, start offsets and key words, a count of headers found, a one-cycle completion pulse, and an error flag for walks that run too deep.

Top module: `hp_parser`

## Requirements
- R1: Bytes presented with `in_valid` while the parser is idle are stored at consecutive offsets from 0. The byte that carries `in_last` ends the packet, and `busy` is high from the next cycle. Each found header reports its start offset in `hdr_base` (8 bits per state id) and its key word in `hdr_key` (16 bits per state id).
- R2: `cfg_we` with the parser idle writes `cfg_wdata` into entry `cfg_addr`. The entry layout is bit 56 entry-enable, [55:52] state, [51:36] compare value, [35:20] care mask, [19:16] next state, [15:8] current header length in bytes, and [7:0] key offset inside the next header. A disabled entry never matches.
- R3: An entry matches when it is enabled, its state equals the current state, and the key agrees with the compare value on every bit set in the care mask. The key is the big-endian 16-bit word at (header start + key offset). The walk begins in state 1 with start 0 and key offset 12.
- R4: When several entries match, the one with the lowest index decides.
- R5: On a match, the current state's valid bit is set, its start offset and key are recorded, and the header count goes up by one. Next state 0 ends the walk with error low. Any other next state continues with the start advanced by the header length.
- R6: When no entry matches, the walk ends with error low. The current state is not marked valid, and the headers found before it stay valid.
- R7: At most 8 headers are recorded. If the 8th recorded header names a nonzero next state, the walk ends with `parse_err` high and a count of 8.
- R8: One lookup is done per cycle. `parse_done` is a one-cycle pulse that comes K cycles after the edge that accepted the last byte, where K is the number of lookups made.
- R9: Table writes and input bytes offered while `busy` is high are ignored.
- R10: Key bytes at offsets at or beyond the received packet length read as zero.
- R11: After reset, `busy`, `parse_done`, `parse_err`, `hdr_valid` and `hdr_count` are all zero.
- R12: The results stay unchanged from the end of a walk until the next packet's last byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Header byte present |
| in_byte | input | 8 | Header byte |
| in_last | input | 1 | Marks the final header byte |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 4 | Table entry index |
| cfg_wdata | input | 57 | Table entry contents |
| busy | output | 1 | Walk in progress |
| parse_done | output | 1 | One-cycle end-of-walk pulse |
| parse_err | output | 1 | Depth limit exceeded |
| hdr_valid | output | 16 | Header found, one bit per state id |
| hdr_count | output | 4 | Number of headers recorded |
| hdr_base | output | 128 | Start offset per state id |
| hdr_key | output | 256 | Key word per state id |

## Verification
The bench uses the default parameters: a 16-entry table, a 96-byte buffer and a depth limit of 8. The 96-byte buffer holds an Ethernet, IPv6 and TCP stack (74 bytes) without truncation. The 16 entries leave room for the ten-entry base graph plus a catch-all, a self-looping state and its entry point. Together these make the priority and depth-overflow cases reachable. A short 22-byte packet that follows a longer one checks that key bytes past the end read as zero, not as leftover data.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int unsigned ST_W  = 4;
    localparam int unsigned KEY_W = 16;
    localparam int unsigned OFF_W = 8;
    localparam int unsigned POS_W = OFF_W + 1;

    // one ternary rule of the parse graph
    typedef struct packed {
        logic             vld;
        logic [ST_W-1:0]  st;
        logic [KEY_W-1:0] val;
        logic [KEY_W-1:0] msk;
        logic [ST_W-1:0]  nxt;
        logic [OFF_W-1:0] len;
        logic [OFF_W-1:0] foff;
    } tcam_ent_t;

    localparam int unsigned ENT_W = $bits(tcam_ent_t);

    typedef struct packed {
        logic             hit;
        logic [ST_W-1:0]  nxt;
        logic [OFF_W-1:0] len;
        logic [OFF_W-1:0] foff;
    } tcam_res_t;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_WALK = 1'b1
    } pstate_e;

endpackage

// File: rtl/hp_tcam.sv
module hp_tcam
    import hp_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 16,
    localparam int unsigned AW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  tcam_ent_t        wr_ent,
    input  logic [ST_W-1:0]  key_st,
    input  logic [KEY_W-1:0] key_val,
    output tcam_res_t        res
);

    tcam_ent_t tbl_d [NUM_ENTRIES];
    tcam_ent_t tbl_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] hit_vec;

    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            tbl_d[i] = tbl_q[i];
            if (wr_en && (wr_addr == AW'(i))) begin
                tbl_d[i] = wr_ent;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

    // per-entry ternary compare
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = tbl_q[g].vld
                          && (tbl_q[g].st == key_st)
                          && (((tbl_q[g].val ^ key_val) & tbl_q[g].msk) == '0);
    end

    // lowest index wins: scan from the top so the last write is the lowest hit
    always_comb begin
        res = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                res.hit  = 1'b1;
                res.nxt  = tbl_q[i].nxt;
                res.len  = tbl_q[i].len;
                res.foff = tbl_q[i].foff;
            end
        end
    end

    // R2: an accepted write is visible in the addressed entry on the next cycle
    p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl_q[$past(wr_addr)] == $past(wr_ent)));

endmodule

// File: rtl/hp_hdr_buf.sv
module hp_hdr_buf
    import hp_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 96,
    localparam int unsigned CNT_W = $clog2(BUF_BYTES + 1),
    localparam int unsigned LP_W  = POS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_en,
    input  logic [7:0]       in_byte,
    input  logic             in_last,
    input  logic [POS_W-1:0] rd_pos,
    output logic [KEY_W-1:0] rd_word
);

    logic [7:0]       mem_d [BUF_BYTES];
    logic [7:0]       mem_q [BUF_BYTES];
    logic [CNT_W-1:0] ptr_d, ptr_q;
    logic [CNT_W-1:0] len_d, len_q;
    logic [LP_W-1:0]  lo_pos;
    logic [7:0]       hi_b, lo_b;

    always_comb begin
        for (int i = 0; i < BUF_BYTES; i++) begin
            mem_d[i] = mem_q[i];
        end
        ptr_d = ptr_q;
        len_d = len_q;
        if (in_en) begin
            for (int i = 0; i < BUF_BYTES; i++) begin
                if (ptr_q == CNT_W'(i)) begin
                    mem_d[i] = in_byte;
                end
            end
            if (in_last) begin
                len_d = (ptr_q < CNT_W'(BUF_BYTES)) ? ptr_q + CNT_W'(1) : ptr_q;
                ptr_d = '0;
            end else if (ptr_q < CNT_W'(BUF_BYTES)) begin
                ptr_d = ptr_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_BYTES; i++) begin
                mem_q[i] <= '0;
            end
            ptr_q <= '0;
            len_q <= '0;
        end else begin
            for (int i = 0; i < BUF_BYTES; i++) begin
                mem_q[i] <= mem_d[i];
            end
            ptr_q <= ptr_d;
            len_q <= len_d;
        end
    end

    // big-endian word fetch, zero past the received length
    assign lo_pos = {1'b0, rd_pos} + LP_W'(1);

    always_comb begin
        hi_b = '0;
        lo_b = '0;
        for (int i = 0; i < BUF_BYTES; i++) begin
            if ((rd_pos == POS_W'(i)) && (CNT_W'(i) < len_q)) begin
                hi_b = mem_q[i];
            end
            if ((lo_pos == LP_W'(i)) && (CNT_W'(i) < len_q)) begin
                lo_b = mem_q[i];
            end
        end
    end

    assign rd_word = {hi_b, lo_b};

    // R10: the recorded length never claims more bytes than are stored
    p_len_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= CNT_W'(BUF_BYTES));

endmodule

// File: rtl/hp_parser.sv
module hp_parser
    import hp_pkg::*;
#(
    parameter int unsigned     NUM_ENTRIES = 16,
    parameter int unsigned     BUF_BYTES   = 96,
    parameter int unsigned     MAX_DEPTH   = 8,
    parameter logic [ST_W-1:0] START_STATE = 4'd1,
    parameter logic [OFF_W-1:0] START_OFF  = 8'd12,
    localparam int unsigned AW      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int unsigned NSTATES = 1 << ST_W,
    localparam int unsigned DEPTH_W = $clog2(MAX_DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [7:0]               in_byte,
    input  logic                     in_last,
    input  logic                     cfg_we,
    input  logic [AW-1:0]            cfg_addr,
    input  logic [ENT_W-1:0]         cfg_wdata,
    output logic                     busy,
    output logic                     parse_done,
    output logic                     parse_err,
    output logic [NSTATES-1:0]       hdr_valid,
    output logic [DEPTH_W-1:0]       hdr_count,
    output logic [NSTATES*OFF_W-1:0] hdr_base,
    output logic [NSTATES*KEY_W-1:0] hdr_key
);

    typedef struct packed {
        pstate_e                         ps;
        logic [ST_W-1:0]                 st;
        logic [OFF_W-1:0]                base;
        logic [OFF_W-1:0]                foff;
        logic [DEPTH_W-1:0]              depth;
        logic                            done;
        logic                            err;
        logic [NSTATES-1:0]              vld;
        logic [NSTATES-1:0][OFF_W-1:0]   bases;
        logic [NSTATES-1:0][KEY_W-1:0]   keys;
    } walk_t;

    walk_t              r_d, r_q;
    logic               take_byte;
    logic               tbl_wr;
    logic [POS_W-1:0]   key_pos;
    logic [KEY_W-1:0]   key_word;
    tcam_res_t          lk;
    logic [DEPTH_W-1:0] depth_inc;

    assign take_byte = in_valid && (r_q.ps == PS_IDLE);
    assign tbl_wr    = cfg_we && (r_q.ps == PS_IDLE);
    assign key_pos   = {1'b0, r_q.base} + {1'b0, r_q.foff};
    assign depth_inc = r_q.depth + DEPTH_W'(1);

    hp_hdr_buf #(
        .BUF_BYTES (BUF_BYTES)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_en   (take_byte),
        .in_byte (in_byte),
        .in_last (in_last),
        .rd_pos  (key_pos),
        .rd_word (key_word)
    );

    hp_tcam #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_tcam (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr),
        .wr_addr (cfg_addr),
        .wr_ent  (tcam_ent_t'(cfg_wdata)),
        .key_st  (r_q.st),
        .key_val (key_word),
        .res     (lk)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.ps)
            PS_IDLE: begin
                if (take_byte && in_last) begin
                    r_d.ps    = PS_WALK;
                    r_d.st    = START_STATE;
                    r_d.base  = '0;
                    r_d.foff  = START_OFF;
                    r_d.depth = '0;
                    r_d.err   = 1'b0;
                    r_d.vld   = '0;
                end
            end
            PS_WALK: begin
                if (!lk.hit) begin
                    r_d.ps   = PS_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.vld[r_q.st]   = 1'b1;
                    r_d.bases[r_q.st] = r_q.base;
                    r_d.keys[r_q.st]  = key_word;
                    r_d.depth         = depth_inc;
                    if (lk.nxt == '0) begin
                        r_d.ps   = PS_IDLE;
                        r_d.done = 1'b1;
                    end else if (depth_inc == DEPTH_W'(MAX_DEPTH)) begin
                        r_d.ps   = PS_IDLE;
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end else begin
                        r_d.st   = lk.nxt;
                        r_d.base = r_q.base + lk.len;
                        r_d.foff = lk.foff;
                    end
                end
            end
            default: r_d.ps = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.ps == PS_WALK);
    assign parse_done = r_q.done;
    assign parse_err  = r_q.err;
    assign hdr_valid  = r_q.vld;
    assign hdr_count  = r_q.depth;
    assign hdr_base   = r_q.bases;
    assign hdr_key    = r_q.keys;

    // R1: the closing byte of an idle packet starts a walk
    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last && !busy) |=> busy);

    // R8: completion is a single-cycle pulse that follows a walk
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        parse_done |=> !parse_done);
    p_done_after_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        parse_done |-> (!busy && $past(busy)));

    // R5: a terminating match ends cleanly
    p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lk.hit && (lk.nxt == '0)) |=> (parse_done && !parse_err));

    // R6: a lookup miss ends the walk without error
    p_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !lk.hit) |=> (parse_done && !parse_err));

    // R7: an error always comes with a full header count
    p_err_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        parse_err |-> (hdr_count == DEPTH_W'(MAX_DEPTH)));

    // R12: results hold while idle unless a new walk begins
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (busy || ($stable(hdr_valid) && $stable(hdr_count) && $stable(parse_err))));

endmodule

// File: tb/hp_parser_bench.sv
module hp_parser_bench;
    import hp_pkg::*;

    typedef struct packed {
        logic [3:0]  kind;
        logic [15:0] vmask;
        logic [3:0]  cnt;
        logic        err;
        logic [3:0]  lat;
        logic [3:0]  cst;
        logic [7:0]  base;
        logic [15:0] key;
    } vec_t;

    // kind, valid mask, count, err, latency, checked state, its start, its key
    localparam vec_t VECS [7] = '{
        '{4'd0, 16'h0016, 4'd3, 1'b0, 4'd3, 4'd2, 8'd14, 16'h4006},
        '{4'd1, 16'h0026, 4'd3, 1'b0, 4'd3, 4'd5, 8'd34, 16'h8786},
        '{4'd2, 16'h0056, 4'd4, 1'b0, 4'd4, 4'd4, 8'd38, 16'h8382},
        '{4'd3, 16'h001A, 4'd3, 1'b0, 4'd3, 4'd3, 8'd14, 16'h0640},
        '{4'd4, 16'h002A, 4'd3, 1'b0, 4'd3, 4'd5, 8'd54, 16'h9392},
        '{4'd5, 16'h0000, 4'd0, 1'b0, 4'd1, 4'd1, 8'd0,  16'h0000},
        '{4'd6, 16'h0002, 4'd1, 1'b0, 4'd2, 4'd1, 8'd0,  16'h0800}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid, in_last, cfg_we;
    logic [7:0]   in_byte;
    logic [3:0]   cfg_addr;
    logic [56:0]  cfg_wdata;
    logic         busy, parse_done, parse_err;
    logic [15:0]  hdr_valid;
    logic [3:0]   hdr_count;
    logic [127:0] hdr_base;
    logic [255:0] hdr_key;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] pkt [128];
    int pkt_len;
    int last_lat;
    logic done_again;

    always #5 clk = ~clk;

    hp_parser u_hp_parser (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_byte (in_byte), .in_last (in_last),
        .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
        .busy (busy), .parse_done (parse_done), .parse_err (parse_err),
        .hdr_valid (hdr_valid), .hdr_count (hdr_count),
        .hdr_base (hdr_base), .hdr_key (hdr_key)
    );

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [56:0] mkent(logic v, logic [3:0] st, logic [15:0] val,
                                          logic [15:0] msk, logic [3:0] nx,
                                          logic [7:0] ln, logic [7:0] off);
        return {v, st, val, msk, nx, ln, off};
    endfunction

    task automatic cfg_write(int a, logic [56:0] e);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 4'(a);
        cfg_wdata = e;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic build(int kind);
        for (int i = 0; i < 128; i++) pkt[i] = 8'(i) ^ 8'hA5;
        case (kind)
            0: begin pkt_len = 54; pkt[12] = 8'h08; pkt[13] = 8'h00; pkt[22] = 8'h40; pkt[23] = 8'h06; end
            1: begin pkt_len = 42; pkt[12] = 8'h08; pkt[13] = 8'h00; pkt[23] = 8'h11; end
            2: begin pkt_len = 58; pkt[12] = 8'h08; pkt[13] = 8'h00; pkt[23] = 8'hFD; end
            3: begin pkt_len = 74; pkt[12] = 8'h86; pkt[13] = 8'hDD; pkt[20] = 8'h06; pkt[21] = 8'h40; end
            4: begin pkt_len = 62; pkt[12] = 8'h86; pkt[13] = 8'hDD; pkt[20] = 8'h11; pkt[21] = 8'h40; end
            5: begin pkt_len = 20; pkt[12] = 8'h12; pkt[13] = 8'h34; end
            6: begin pkt_len = 40; pkt[12] = 8'h08; pkt[13] = 8'h00; pkt[22] = 8'h40; pkt[23] = 8'h33; end
            7: begin pkt_len = 30; pkt[12] = 8'h88; pkt[13] = 8'hB5; end
            default: begin pkt_len = 22; pkt[12] = 8'h08; pkt[13] = 8'h00; end
        endcase
    endtask

    // drives a packet, measures edges from last-byte acceptance to done
    task automatic run_pkt(int kind, bit inject);
        int cycles;
        bit seen;
        build(kind);
        for (int i = 0; i < pkt_len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = pkt[i];
            in_last  = (i == pkt_len - 1);
        end
        cycles = 0;
        seen   = 1'b0;
        while (!seen && cycles < 40) begin
            @(negedge clk);
            cycles++;
            in_valid = 1'b0;
            in_last  = 1'b0;
            cfg_we   = 1'b0;
            if (inject && cycles == 1) begin
                cfg_we    = 1'b1;
                cfg_addr  = 4'd0;
                cfg_wdata = '0;
                in_valid  = 1'b1;
                in_last   = 1'b1;
                in_byte   = 8'h00;
            end
            if (parse_done) seen = 1'b1;
        end
        last_lat = seen ? cycles - 1 : -1;
        #1;
    endtask

    task automatic check_res(vec_t v);
        string vreq;
        vreq = (v.kind == 4'd5 || v.kind == 4'd6) ? "R6" : "R5";
        chk("R8", "latency", last_lat, 32'(v.lat));
        chk("R7", "error flag", 32'(parse_err), 32'(v.err));
        chk(vreq, "valid mask", 32'(hdr_valid), 32'(v.vmask));
        chk(vreq, "header count", 32'(hdr_count), 32'(v.cnt));
        if (v.vmask[v.cst]) begin
            chk("R1", "start offset", 32'(hdr_base[v.cst*8 +: 8]), 32'(v.base));
            chk("R1", "key word", 32'(hdr_key[v.cst*16 +: 16]), 32'(v.key));
        end
        @(negedge clk);
        done_again = parse_done;
        chk("R8", "done pulse width", 32'(done_again), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        vec_t v;
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_last   = 1'b0;
        in_byte   = '0;
        cfg_we    = 1'b0;
        cfg_addr  = '0;
        cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk("R11", "busy", 32'(busy), 0);
        chk("R11", "done", 32'(parse_done), 0);
        chk("R11", "err", 32'(parse_err), 0);
        chk("R11", "valid", 32'(hdr_valid), 0);
        chk("R11", "count", 32'(hdr_count), 0);

        // base graph, R2 layout; R3 big-endian keys with care masks
        cfg_write(0, mkent(1, 4'd1, 16'h0800, 16'hFFFF, 4'd2, 8'd14, 8'd8));
        cfg_write(1, mkent(1, 4'd1, 16'h86DD, 16'hFFFF, 4'd3, 8'd14, 8'd6));
        cfg_write(2, mkent(1, 4'd2, 16'h0006, 16'h00FF, 4'd4, 8'd20, 8'd0));
        cfg_write(3, mkent(1, 4'd2, 16'h0011, 16'h00FF, 4'd5, 8'd20, 8'd0));
        cfg_write(4, mkent(1, 4'd2, 16'h00FD, 16'h00FF, 4'd6, 8'd20, 8'd0));
        cfg_write(5, mkent(1, 4'd6, 16'h0000, 16'h0000, 4'd4, 8'd4,  8'd0));
        cfg_write(6, mkent(1, 4'd4, 16'h0000, 16'h0000, 4'd0, 8'd20, 8'd0));
        cfg_write(7, mkent(1, 4'd5, 16'h0000, 16'h0000, 4'd0, 8'd8,  8'd0));
        cfg_write(8, mkent(1, 4'd3, 16'h0600, 16'hFF00, 4'd4, 8'd40, 8'd0));
        cfg_write(9, mkent(1, 4'd3, 16'h1100, 16'hFF00, 4'd5, 8'd40, 8'd0));

        for (int k = 0; k < 7; k++) begin
            run_pkt(int'(VECS[k].kind), 1'b0);
            check_res(VECS[k]);
        end

        // R5: catch-all for IPv4 accepts an unknown protocol
        cfg_write(10, mkent(1, 4'd2, 16'h0000, 16'h0000, 4'd0, 8'd20, 8'd0));
        run_pkt(6, 1'b0);
        v = '{4'd6, 16'h0006, 4'd2, 1'b0, 4'd2, 4'd2, 8'd14, 16'h4033};
        check_res(v);

        // R4: entry 2 and entry 10 both match TCP; entry 2 decides
        run_pkt(0, 1'b0);
        check_res(VECS[0]);
        chk("R4", "lowest index wins", 32'(hdr_valid[4]), 1);

        // R10: short packet, protocol bytes beyond length read as zero
        run_pkt(8, 1'b0);
        v = '{4'd8, 16'h0006, 4'd2, 1'b0, 4'd2, 4'd2, 8'd14, 16'h0000};
        check_res(v);
        chk("R10", "zero-filled key", 32'(hdr_key[2*16 +: 16]), 0);

        // R7: self-looping state exceeds the depth limit
        cfg_write(11, mkent(1, 4'd7, 16'h0000, 16'h0000, 4'd7, 8'd1,  8'd0));
        cfg_write(12, mkent(1, 4'd1, 16'h88B5, 16'hFFFF, 4'd7, 8'd14, 8'd0));
        run_pkt(7, 1'b0);
        v = '{4'd7, 16'h0082, 4'd8, 1'b1, 4'd8, 4'd1, 8'd0, 16'h88B5};
        check_res(v);
        run_pkt(1, 1'b0);
        check_res(VECS[1]);

        // R2 / R3: a disabled entry never matches
        cfg_write(12, mkent(0, 4'd1, 16'h88B5, 16'hFFFF, 4'd7, 8'd14, 8'd0));
        run_pkt(7, 1'b0);
        v = '{4'd7, 16'h0000, 4'd0, 1'b0, 4'd1, 4'd1, 8'd0, 16'h0000};
        check_res(v);
        chk("R3", "disabled entry", 32'(hdr_valid[1]), 0);

        // R9: table write and closing byte offered mid-walk
        run_pkt(0, 1'b1);
        check_res(VECS[0]);
        repeat (3) @(negedge clk);
        chk("R9", "no walk from ignored byte", 32'(busy), 0);
        chk("R12", "results held", 32'(hdr_valid), 32'h0016);
        run_pkt(0, 1'b0);
        check_res(VECS[0]);
        chk("R9", "entry 0 kept", 32'(hdr_valid[2]), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule